// File: doc/BRIEF.md
# Vectored Priority Interrupt Arbiter

This block gathers interrupt requests from a set of peripheral channels and presents them to a processor as one interrupt line. Each channel has its own request wire and its own acknowledge wire. The processor answers the interrupt by raising its acknowledge input. The block then picks one pending channel, returns an acknowledge to that channel only, and drives the channel's programmed 8-bit vector index onto the read-data bus. Software uses that index to select an entry in a 256-entry handler table.

A small register port, used only for configuration, holds four things: a per-channel mask, one vector index per channel, a global enable and a priority-mode select. In fixed mode the lowest-numbered channel always ranks highest. In rotating mode the channel that was served last drops to the bottom of the order. A grant is held for as long as the processor keeps its acknowledge high. It is released when the acknowledge drops, and the pending requests are then judged afresh.

Top module: `vec_irq_arbiter`

## Requirements
- R1: `irq_o` is high exactly when the enable bit is set and at least one channel has both its request and its mask bit high. With the enable clear or all mask bits clear, `irq_o` stays low.
- R2: Suppose `irq_ack_i` is sampled high on a clock edge while no grant is held and `irq_o` is high. After that edge, exactly one bit of `ack_o` is high, and it belongs to a channel that was requesting and unmasked.
- R3: In fixed mode (control bit 1 = 0), the lowest-numbered pending channel wins, regardless of earlier grants.
- R4: In rotating mode (control bit 1 = 1), the search starts at the channel after the last one granted, so the channel just served ranks lowest. After reset, channel 0 ranks highest.
- R5: The register map for NUM_CH channels is as follows. Offset 0 is the mask, with bit k enabling channel k. Offsets 1 to NUM_CH hold the vector indices of channels 0 to NUM_CH-1. Offset NUM_CH+1 is the control register, with bit 0 as the global enable and bit 1 as the mode select.
- R6: When no grant is held, `bus_rdata_o` shows the stored value of the register at `bus_addr_i`, and an unmapped address reads 0. A write is visible from the clock edge that samples `bus_wr_i`. A write to an unmapped address changes nothing.
- R7: Reset clears the mask, every vector index and the control register to 0, and drives `ack_o` and `irq_o` low.
- R8: While a grant is held, `bus_rdata_o` shows the winning channel's vector index.
- R9: While `irq_ack_i` stays high, the granted channel and `ack_o` stay unchanged, even if requests change. After the edge that samples `irq_ack_i` low, `ack_o` is 0. The next acknowledge re-arbitrates among the requests pending at that time.
- R10: If `irq_ack_i` is high but nothing is pending, `ack_o` stays 0. A request that becomes pending while the acknowledge is still high is granted on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | NUM_CH | Per-channel interrupt requests |
| ack_o | output | NUM_CH | Per-channel acknowledge, one-hot while a grant is held |
| irq_o | output | 1 | Interrupt line to the processor |
| irq_ack_i | input | 1 | Interrupt acknowledge from the processor |
| bus_addr_i | input | ADDR_W | Register offset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data, or the winner's vector during a grant |

## Verification
The bench uses the default of two channels with a 4-bit address, so the control register sits at offset 3. This leaves offsets 4 to 15 unmapped, which makes the unmapped-read and unmapped-write cases reachable. With only two channels, a rotating run alternates visibly between the channels, so each step of the rotation history can be predicted and checked. It can also be set against the fixed order on the same request pattern.

// File: rtl/via_pkg.sv
// Shared types for the vectored interrupt arbiter.
// Assumes an 8-bit configuration data path.
package via_pkg;
    localparam int VEC_W = 8;
    typedef logic [VEC_W-1:0] vec_t;
    typedef enum logic {
        PRI_FIXED  = 1'b0,
        PRI_ROTATE = 1'b1
    } pri_mode_e;
endpackage

// File: rtl/via_regs.sv
// Configuration register file: mask, per-channel vector indices, control.
// Assumes NUM_CH <= 8 and an address width wide enough for NUM_CH+2 offsets.
module via_regs
    import via_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  vec_t              wdata,
    output logic [NUM_CH-1:0] mask_o,
    output vec_t              vec_o [NUM_CH],
    output logic              enable_o,
    output pri_mode_e         mode_o,
    output vec_t              rdata_o
);
    localparam int CTRL_OFS = NUM_CH + 1;

    logic [NUM_CH-1:0] mask_q;
    vec_t              vec_q [NUM_CH];
    logic [1:0]        ctrl_q;

    // Register writes, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            ctrl_q <= '0;
            for (int k = 0; k < NUM_CH; k++) vec_q[k] <= '0;
        end else if (wr_en) begin
            if (addr == '0) mask_q <= wdata[NUM_CH-1:0];
            if (addr == ADDR_W'(CTRL_OFS)) ctrl_q <= wdata[1:0];
            for (int k = 0; k < NUM_CH; k++)
                if (addr == ADDR_W'(k + 1)) vec_q[k] <= wdata;
        end
    end

    // Read decode; unmapped offsets return zero.
    always_comb begin
        rdata_o = '0;
        if (addr == '0) rdata_o = vec_t'(mask_q);
        if (addr == ADDR_W'(CTRL_OFS)) rdata_o = vec_t'(ctrl_q);
        for (int k = 0; k < NUM_CH; k++)
            if (addr == ADDR_W'(k + 1)) rdata_o = vec_q[k];
    end

    assign mask_o   = mask_q;
    assign vec_o    = vec_q;
    assign enable_o = ctrl_q[0];
    assign mode_o   = pri_mode_e'(ctrl_q[1]);
endmodule

// File: rtl/via_pick.sv
// Combinational winner selection over pending channels.
// Fixed mode scans from channel 0; rotating mode scans from last_idx+1.
module via_pick
    import via_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0] pending,
    input  pri_mode_e         mode,
    input  logic [IDX_W-1:0]  last_idx,
    output logic              any_o,
    output logic [IDX_W-1:0]  win_o
);
    // First pending channel in the scan order chosen by the mode.
    always_comb begin
        int base;
        int cand;
        logic found;
        base  = (mode == PRI_ROTATE) ? int'(last_idx) + 1 : 0;
        found = 1'b0;
        win_o = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            cand = (base + i) % NUM_CH;
            if (!found && pending[cand]) begin
                found = 1'b1;
                win_o = IDX_W'(cand);
            end
        end
        any_o = found;
    end
endmodule

// File: rtl/via_grant.sv
// Acknowledge handshake: latches a winner when acknowledge is seen with a
// pending request, holds it until acknowledge drops, tracks service history.
module via_grant #(
    parameter int NUM_CH = 2,
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_ack_i,
    input  logic              any_i,
    input  logic [IDX_W-1:0]  win_i,
    output logic              busy_o,
    output logic [IDX_W-1:0]  win_q_o,
    output logic [IDX_W-1:0]  last_o,
    output logic [NUM_CH-1:0] ack_o
);
    logic             busy_q;
    logic [IDX_W-1:0] win_q;
    logic [IDX_W-1:0] last_q;

    // Grant capture, hold and release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            win_q  <= '0;
            last_q <= IDX_W'(NUM_CH - 1);
        end else if (!irq_ack_i) begin
            busy_q <= 1'b0;
        end else if (!busy_q && any_i) begin
            busy_q <= 1'b1;
            win_q  <= win_i;
            last_q <= win_i;
        end
    end

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ack
        assign ack_o[k] = busy_q && (win_q == IDX_W'(k));
    end

    assign busy_o  = busy_q;
    assign win_q_o = win_q;
    assign last_o  = last_q;
endmodule

// File: rtl/vec_irq_arbiter.sv
// Vectored priority interrupt arbiter top level. Combines masked requests
// into one interrupt, arbitrates on acknowledge, and returns the winner's
// vector index on the read bus. Assumes NUM_CH <= 8.
module vec_irq_arbiter
    import via_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 4,
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] req_i,
    output logic [NUM_CH-1:0] ack_o,
    output logic              irq_o,
    input  logic              irq_ack_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic [7:0]        bus_wdata_i,
    output logic [7:0]        bus_rdata_o
);
    logic [NUM_CH-1:0] mask_w;
    vec_t              vec_w [NUM_CH];
    logic              en_w;
    pri_mode_e         mode_w;
    vec_t              reg_rdata;
    logic [NUM_CH-1:0] pending;
    logic              any_w;
    logic [IDX_W-1:0]  pick_w;
    logic              busy_w;
    logic [IDX_W-1:0]  win_w;
    logic [IDX_W-1:0]  last_w;
    logic              rot_w;

    via_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_i), .addr(bus_addr_i),
        .wdata(bus_wdata_i), .mask_o(mask_w), .vec_o(vec_w),
        .enable_o(en_w), .mode_o(mode_w), .rdata_o(reg_rdata)
    );

    // Pending set: requests that pass both mask and global enable.
    assign pending = req_i & mask_w & {NUM_CH{en_w}};
    assign irq_o   = |pending;
    assign rot_w   = (mode_w == PRI_ROTATE);

    via_pick #(.NUM_CH(NUM_CH)) u_pick (
        .pending(pending), .mode(mode_w), .last_idx(last_w),
        .any_o(any_w), .win_o(pick_w)
    );

    via_grant #(.NUM_CH(NUM_CH)) u_grant (
        .clk(clk), .rst_n(rst_n), .irq_ack_i(irq_ack_i), .any_i(any_w),
        .win_i(pick_w), .busy_o(busy_w), .win_q_o(win_w), .last_o(last_w),
        .ack_o(ack_o)
    );

    // Read bus: winner's vector during a grant, otherwise register data.
    assign bus_rdata_o = busy_w ? vec_w[win_w] : reg_rdata;
endmodule

// File: rtl/via_arbiter_chk.sv
// Property checker for vec_irq_arbiter, attached through bind.
module via_arbiter_chk #(
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] req_i,
    input logic [NUM_CH-1:0] ack_o,
    input logic              irq_o,
    input logic              irq_ack_i,
    input logic [NUM_CH-1:0] mask,
    input logic              enable,
    input logic              rotate
);
    // R1
    irq_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((req_i & mask) != '0));
    // R1
    irq_off_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !irq_o);
    // R2
    ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_o));
    // R2
    ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o != '0 && $past(ack_o) == '0) |->
            ($past(irq_ack_i) && (($past(req_i & mask) & ack_o) != '0)));
    // R3
    fixed_top_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o != '0 && $past(ack_o) == '0 && !$past(rotate)
         && $past(req_i[0] & mask[0])) |-> ack_o[0]);
    // R9
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o != '0 && irq_ack_i) |=> $stable(ack_o));
    // R9
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_ack_i |=> (ack_o == '0));
endmodule

bind vec_irq_arbiter via_arbiter_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .ack_o(ack_o), .irq_o(irq_o),
    .irq_ack_i(irq_ack_i), .mask(mask_w), .enable(en_w), .rotate(rot_w)
);

// File: tb/vec_irq_arbiter_test.sv
module vec_irq_arbiter_test;
    localparam int NCH = 2;
    localparam int AW  = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] req = '0;
    logic [NCH-1:0] ack;
    logic           irq;
    logic           iack = 1'b0;
    logic [AW-1:0]  addr = '0;
    logic           wr = 1'b0;
    logic [7:0]     wdata = '0;
    logic [7:0]     rdata;
    int checks = 0;
    int fails  = 0;

    vec_irq_arbiter #(.NUM_CH(NCH), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .ack_o(ack), .irq_o(irq),
        .irq_ack_i(iack), .bus_addr_i(addr), .bus_wr_i(wr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic wreg(input int a, input int d);
        addr = AW'(a); wdata = 8'(d); wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; addr = '0;
    endtask

    task automatic rreg(input int a, input int exp, input string rq);
        addr = AW'(a);
        #1;
        check(rdata == 8'(exp), rq, rdata, exp);
        addr = '0;
    endtask

    // ctrl, mask, req, expected ack, expected vector
    typedef struct packed {
        logic [1:0] ctrl; logic [1:0] mask; logic [1:0] rq;
        logic [1:0] eack; logic [7:0] evec;
    } row_t;
    localparam row_t TBL [11] = '{
        '{2'b01, 2'b11, 2'b11, 2'b01, 8'h2A},  // R3 fixed both
        '{2'b01, 2'b11, 2'b11, 2'b01, 8'h2A},  // R3 fixed does not rotate
        '{2'b01, 2'b11, 2'b10, 2'b10, 8'hC5},  // R2 single requester
        '{2'b01, 2'b10, 2'b11, 2'b10, 8'hC5},  // R1 mask hides ch0
        '{2'b11, 2'b11, 2'b11, 2'b01, 8'h2A},  // R4 after ch1 served
        '{2'b11, 2'b11, 2'b11, 2'b10, 8'hC5},  // R4
        '{2'b11, 2'b11, 2'b11, 2'b01, 8'h2A},  // R4
        '{2'b11, 2'b11, 2'b01, 2'b01, 8'h2A},  // R4 only ch0
        '{2'b11, 2'b11, 2'b11, 2'b10, 8'hC5},  // R4
        '{2'b11, 2'b00, 2'b11, 2'b00, 8'h00},  // R1 all masked
        '{2'b10, 2'b11, 2'b11, 2'b00, 8'h00}   // R1 disabled
    };

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R9 actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        req = 2'b11;
        repeat (3) @(negedge clk);
        // R7 reset state
        check(irq == 1'b0, "R7 irq", irq, 0);
        check(ack == '0, "R7 ack", ack, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int a = 0; a < 4; a++) rreg(a, 0, "R7 reg cleared");
        check(irq == 1'b0, "R1 irq low while disabled", irq, 0);
        req = '0;

        // R5 / R6 map and readback
        wreg(1, 8'h2A);
        rreg(1, 8'h2A, "R6 write visible next cycle");
        wreg(2, 8'hC5);
        wreg(0, 8'h03);
        wreg(3, 8'h01);
        rreg(0, 8'h03, "R5 mask offset");
        rreg(2, 8'hC5, "R5 ch1 vector offset");
        rreg(3, 8'h01, "R5 control offset");
        wreg(7, 8'hFF);
        rreg(7, 0, "R6 unmapped read");
        rreg(0, 8'h03, "R6 unmapped write ignored");
        rreg(3, 8'h01, "R6 unmapped write ignored");

        // table walk
        for (int i = 0; i < 11; i++) begin
            wreg(0, TBL[i].mask);
            wreg(3, TBL[i].ctrl);
            req = TBL[i].rq;
            @(negedge clk);
            check(irq == (TBL[i].eack != '0), "R1 irq", irq, int'(TBL[i].eack != '0));
            iack = 1'b1;
            @(negedge clk);
            check(ack == TBL[i].eack, "R2 R3 R4 ack", ack, TBL[i].eack);
            if (TBL[i].eack != '0)
                check(rdata == TBL[i].evec, "R8 vector", rdata, TBL[i].evec);
            iack = 1'b0;
            req = '0;
            @(negedge clk);
            check(ack == '0, "R9 release", ack, 0);
        end

        // R9 hold while requests change
        wreg(0, 8'h03);
        wreg(3, 8'h01);
        req = 2'b10;
        @(negedge clk);
        iack = 1'b1;
        @(negedge clk);
        check(ack == 2'b10, "R9 grant", ack, 2);
        req = 2'b01;
        @(negedge clk);
        @(negedge clk);
        check(ack == 2'b10, "R9 hold", ack, 2);
        check(rdata == 8'hC5, "R8 hold vector", rdata, 8'hC5);
        iack = 1'b0;
        @(negedge clk);
        check(ack == '0, "R9 release", ack, 0);
        check(irq == 1'b1, "R1 new pending", irq, 1);
        iack = 1'b1;
        @(negedge clk);
        check(ack == 2'b01, "R9 re-arbitrate", ack, 1);
        iack = 1'b0;
        req = '0;
        @(negedge clk);

        // R10 acknowledge with nothing pending
        iack = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(ack == '0, "R10 no grant", ack, 0);
        rreg(0, 8'h03, "R6 read while idle ack");
        req = 2'b10;
        @(negedge clk);
        check(ack == 2'b10, "R10 late request", ack, 2);
        iack = 1'b0;
        req = '0;
        @(negedge clk);

        // R7 reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int a = 0; a < 4; a++) rreg(a, 0, "R7 reset clears");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule